// File: doc/BRIEF.md
# Register File with Single-Cycle Bulk Clear

This block is a general-purpose register file with two combinational read ports, one synchronous write port and a clear port. The clear port takes a bitmask with one bit per register and a strobe. In one clock it can zero any subset of registers. It does this without touching the data array: each register owns a one-bit flag meaning "reads as zero", and a clear only sets flags. A later write to a flagged register stores the new word and drops its flag.

The block suits code that must wipe many registers at once, for example on entry to or exit from a sensitive routine. A write and a read of the same register in the same cycle are bypassed, so the reader sees the new data. A clear in the same cycle as a read is seen at once, and the reader gets zero. Register 0 always reads as zero.

Top module: `zclr_regfile`

## Requirements
- R1: A synchronous active-high reset sets every flag, so in the cycles after reset every register reads as zero on both ports.
- R2: With the write enable high, the write data is stored into the addressed register at the clock edge and its flag is dropped. From the next cycle both ports return that value.
- R3: With the clear strobe high, every register whose bit is set in the mask (bit i selects register i) reads as zero from the next cycle. Registers whose mask bit is 0 keep their values.
- R4: Register 0 always reads as zero. Writes and clears aimed at it have no effect.
- R5: When a write and a clear select the same register in the same cycle, the clear wins and the register reads as zero afterwards.
- R6: A read of the register being written in the same cycle returns the incoming write data.
- R7: A read of a register selected by an active clear in the same cycle returns zero, even when that register is also being written.
- R8: The two read ports are independent, and both may address the same register.
- R9: With the clear strobe low, the mask has no effect on any register.
- R10: With the write enable low, the write address and data have no effect.
- R11: While reset is high, writes and clears are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset; marks all registers zero |
| wrEn | input | 1 | Write enable |
| wrAddr | input | 5 | Register written |
| wrData | input | 64 | Data written |
| clrStrobe | input | 1 | Applies clrMask this cycle |
| clrMask | input | 32 | Bit i selects register i for clearing |
| rdAddrA | input | 5 | Read port A address |
| rdDataA | output | 64 | Read port A data (combinational) |
| rdAddrB | input | 5 | Read port B address |
| rdDataB | output | 64 | Read port B data (combinational) |

## Verification
A wrong flag appears at the ports in the very next cycle. A read of that register either returns stale stored data where zero was expected, or returns zero where a written value was expected. A fault in the bypass or same-cycle clear path shows in the same cycle as the stimulus, because the read ports are combinational. The bench therefore checks reads both in the cycle of each write or clear and in the cycle after it. It also checks registers the mask did not select, which exposes a clear that spreads too far.

// File: rtl/zclr_pkg.sv
package zclr_pkg;

  // Strobes the control half hands to the datapath each cycle.
  typedef struct packed {
    logic wrGo;   // write accepted this cycle (enable, not in reset, non-zero target)
    logic clrGo;  // clear accepted this cycle (strobe, not in reset)
  } zclr_strobe_t;

endpackage

// File: rtl/zclr_ctrl.sv
module zclr_ctrl
  import zclr_pkg::*;
#(
  parameter int NumRegs = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wrEn,
  input  logic [$clog2(NumRegs)-1:0]   wrAddr,
  input  logic                         clrStrobe,
  input  logic [NumRegs-1:0]           clrMask,
  output zclr_strobe_t                 strb,
  output logic [NumRegs-1:0]           zeroFlag,
  output logic [NumRegs-1:0]           clrSel
);

  localparam int AddrWidth = $clog2(NumRegs);

  logic [NumRegs-1:0] flagQ;
  logic [NumRegs-1:0] wrDec;
  logic [NumRegs-1:0] clrVec;
  logic [NumRegs-1:0] flagNext;

  always_comb begin
    strb.wrGo  = wrEn && !rst && (wrAddr != '0);
    strb.clrGo = clrStrobe && !rst;
  end

  // Register 0 is always treated as selected by a clear.
  assign clrSel = clrMask | {{(NumRegs-1){1'b0}}, 1'b1};

  genvar gi;
  generate
    for (gi = 0; gi < NumRegs; gi++) begin : g_dec
      assign wrDec[gi]  = strb.wrGo && (wrAddr == AddrWidth'(gi));
      assign clrVec[gi] = strb.clrGo && clrSel[gi];
    end
  endgenerate

  // A clear on the same register overrides the write's flag drop.
  assign flagNext = (flagQ & ~wrDec) | clrVec | {{(NumRegs-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst) flagQ <= '1;
    else     flagQ <= flagNext;
  end

  assign zeroFlag = flagQ;

  assert_reset_flags_R1: assert property (@(posedge clk)
    rst |=> (&flagQ));

  assert_clear_sets_R3: assert property (@(posedge clk) disable iff (rst)
    (clrStrobe) |=> ((flagQ & $past(clrMask)) == $past(clrMask)));

  assert_write_drops_R2: assert property (@(posedge clk) disable iff (rst)
    (wrEn && (wrAddr != '0) && !(clrStrobe && clrMask[wrAddr]))
      |=> !flagQ[$past(wrAddr)]);

  assert_write_clear_tie_R5: assert property (@(posedge clk) disable iff (rst)
    (wrEn && clrStrobe && clrMask[wrAddr]) |=> flagQ[$past(wrAddr)]);

  assert_reg0_zero_R4: assert property (@(posedge clk) disable iff (rst)
    flagQ[0]);

  assert_no_strobe_R9: assert property (@(posedge clk) disable iff (rst)
    (!clrStrobe && !wrEn) |=> (flagQ == $past(flagQ)));

endmodule

// File: rtl/zclr_datapath.sv
module zclr_datapath
  import zclr_pkg::*;
#(
  parameter int NumRegs    = 32,
  parameter int DataWidth  = 64,
  parameter int NumRdPorts = 2
) (
  input  logic                                        clk,
  input  logic                                        rst,
  input  zclr_strobe_t                                strb,
  input  logic [$clog2(NumRegs)-1:0]                  wrAddr,
  input  logic [DataWidth-1:0]                        wrData,
  input  logic [NumRegs-1:0]                          zeroFlag,
  input  logic [NumRegs-1:0]                          clrSel,
  input  logic [NumRdPorts-1:0][$clog2(NumRegs)-1:0]  rdAddr,
  output logic [NumRdPorts-1:0][DataWidth-1:0]        rdData
);

  localparam int AddrWidth = $clog2(NumRegs);

  // Storage is never reset; the flags decide what is visible.
  logic [DataWidth-1:0] mem [NumRegs];

  always_ff @(posedge clk) begin
    if (strb.wrGo) mem[wrAddr] <= wrData;
  end

  genvar gp;
  generate
    for (gp = 0; gp < NumRdPorts; gp++) begin : g_rd
      logic [AddrWidth-1:0] addr;
      logic clrHit;
      logic wrHit;
      assign addr   = rdAddr[gp];
      assign clrHit = strb.clrGo && clrSel[addr];
      assign wrHit  = strb.wrGo && (wrAddr == addr);
      always_comb begin
        if (addr == '0)         rdData[gp] = '0;
        else if (clrHit)        rdData[gp] = '0;
        else if (wrHit)         rdData[gp] = wrData;
        else if (zeroFlag[addr]) rdData[gp] = '0;
        else                    rdData[gp] = mem[addr];
      end
    end
  endgenerate

  assert_store_commit_R2: assert property (@(posedge clk) disable iff (rst)
    strb.wrGo |=> (mem[$past(wrAddr)] == $past(wrData)));

endmodule

// File: rtl/zclr_regfile.sv
module zclr_regfile
  import zclr_pkg::*;
#(
  parameter int NumRegs   = 32,
  parameter int DataWidth = 64
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wrEn,
  input  logic [$clog2(NumRegs)-1:0]   wrAddr,
  input  logic [DataWidth-1:0]         wrData,
  input  logic                         clrStrobe,
  input  logic [NumRegs-1:0]           clrMask,
  input  logic [$clog2(NumRegs)-1:0]   rdAddrA,
  output logic [DataWidth-1:0]         rdDataA,
  input  logic [$clog2(NumRegs)-1:0]   rdAddrB,
  output logic [DataWidth-1:0]         rdDataB
);

  localparam int AddrWidth  = $clog2(NumRegs);
  localparam int NumRdPorts = 2;

  zclr_strobe_t                           strb;
  logic [NumRegs-1:0]                     zeroFlag;
  logic [NumRegs-1:0]                     clrSel;
  logic [NumRdPorts-1:0][AddrWidth-1:0]   rdAddr;
  logic [NumRdPorts-1:0][DataWidth-1:0]   rdData;

  assign rdAddr  = {rdAddrB, rdAddrA};
  assign rdDataA = rdData[0];
  assign rdDataB = rdData[1];

  zclr_ctrl #(.NumRegs(NumRegs)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .clrStrobe (clrStrobe),
    .clrMask   (clrMask),
    .strb      (strb),
    .zeroFlag  (zeroFlag),
    .clrSel    (clrSel)
  );

  zclr_datapath #(
    .NumRegs    (NumRegs),
    .DataWidth  (DataWidth),
    .NumRdPorts (NumRdPorts)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strb     (strb),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .zeroFlag (zeroFlag),
    .clrSel   (clrSel),
    .rdAddr   (rdAddr),
    .rdData   (rdData)
  );

endmodule

// File: tb/zclr_regfile_bench.sv
module zclr_regfile_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0;
  logic [4:0]  wrAddr = '0;
  logic [63:0] wrData = '0;
  logic        clrStrobe = 1'b0;
  logic [31:0] clrMask = '0;
  logic [4:0]  rdAddrA = '0;
  logic [4:0]  rdAddrB = '0;
  logic [63:0] rdDataA;
  logic [63:0] rdDataB;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  zclr_regfile u_zclr_regfile (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .clrStrobe(clrStrobe), .clrMask(clrMask),
    .rdAddrA(rdAddrA), .rdDataA(rdDataA), .rdAddrB(rdAddrB), .rdDataB(rdDataB)
  );

  typedef struct packed {
    logic        we;
    logic [4:0]  wa;
    logic [63:0] wd;
    logic        cs;
    logic [31:0] cm;
    logic [4:0]  ra;
    logic [4:0]  rb;
    logic [63:0] ea;
    logic [63:0] eb;
    logic [7:0]  req;
  } vec_t;

  localparam logic [63:0] VA = 64'hA5A5_0000_1111_2222;
  localparam logic [63:0] VB = 64'h0123_4567_89AB_CDEF;
  localparam logic [63:0] VC = 64'hFFFF_FFFF_FFFF_FFFE;
  localparam logic [63:0] VD = 64'h0000_0000_DEAD_BEEF;
  localparam logic [63:0] VE = 64'h7777_7777_7777_7777;
  localparam logic [63:0] VF = 64'h8000_0000_0000_0001;
  localparam int NVEC = 14;

  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 5'd5, VA, 1'b0, 32'h0, 5'd5, 5'd5, VA, VA, 8'd6},                 // R6 bypass
    '{1'b1, 5'd7, VB, 1'b0, 32'h0, 5'd5, 5'd7, VA, VB, 8'd2},                 // R2 stored
    '{1'b1, 5'd9, VC, 1'b0, 32'h0, 5'd7, 5'd9, VB, VC, 8'd2},                 // R2
    '{1'b0, 5'd0, 64'd0, 1'b1, 32'h0000_0220, 5'd5, 5'd7, 64'd0, VB, 8'd7},   // R7 same-cycle clear
    '{1'b0, 5'd0, 64'd0, 1'b0, 32'h0, 5'd5, 5'd9, 64'd0, 64'd0, 8'd3},        // R3 selected
    '{1'b0, 5'd0, 64'd0, 1'b0, 32'h0, 5'd7, 5'd9, VB, 64'd0, 8'd3},           // R3 unselected kept
    '{1'b1, 5'd9, VD, 1'b1, 32'h0000_0200, 5'd9, 5'd7, 64'd0, VB, 8'd7},      // R7 clear beats write
    '{1'b0, 5'd0, 64'd0, 1'b0, 32'h0, 5'd9, 5'd9, 64'd0, 64'd0, 8'd5},        // R5 clear wins
    '{1'b1, 5'd0, VE, 1'b1, 32'h0000_0001, 5'd0, 5'd0, 64'd0, 64'd0, 8'd4},   // R4 reg 0
    '{1'b0, 5'd0, 64'd0, 1'b0, 32'h0, 5'd0, 5'd7, 64'd0, VB, 8'd4},           // R4
    '{1'b0, 5'd7, VF, 1'b0, 32'hFFFF_FFFF, 5'd7, 5'd7, VB, VB, 8'd10},        // R10 R9 idle inputs
    '{1'b0, 5'd0, 64'd0, 1'b0, 32'h0, 5'd7, 5'd5, VB, 64'd0, 8'd9},           // R9 mask ignored
    '{1'b1, 5'd5, VF, 1'b0, 32'h0, 5'd5, 5'd7, VF, VB, 8'd2},                 // R2 rewrite
    '{1'b0, 5'd0, 64'd0, 1'b0, 32'h0, 5'd5, 5'd5, VF, VF, 8'd8}               // R8 both ports
  };

  task automatic check(input int req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    wrEn = 1'b0; wrAddr = '0; wrData = '0; clrStrobe = 1'b0; clrMask = '0;
  endtask

  initial begin : watchdog
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog expired: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: every register reads zero after reset, on both ports
    for (int r = 0; r < 32; r += 2) begin
      rdAddrA = 5'(r);
      rdAddrB = 5'(r + 1);
      #1;
      check(1, "reset state port A", rdDataA, 64'd0);
      check(1, "reset state port B", rdDataB, 64'd0);
    end

    // Vector table: inputs applied after a falling edge, outputs sampled before the rising edge
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      wrEn = VECS[i].we; wrAddr = VECS[i].wa; wrData = VECS[i].wd;
      clrStrobe = VECS[i].cs; clrMask = VECS[i].cm;
      rdAddrA = VECS[i].ra; rdAddrB = VECS[i].rb;
      #2;
      check(int'(VECS[i].req), $sformatf("vector %0d port A", i), rdDataA, VECS[i].ea);
      check(int'(VECS[i].req), $sformatf("vector %0d port B", i), rdDataB, VECS[i].eb);
    end

    // R3: clear of many registers at once, leaving the others intact
    for (int r = 1; r < 32; r++) begin
      @(negedge clk);
      idle();
      wrEn = 1'b1; wrAddr = 5'(r); wrData = 64'(r) * 64'h0101_0101_0101_0101;
    end
    @(negedge clk);
    idle();
    clrStrobe = 1'b1; clrMask = 32'hAAAA_5555;
    @(negedge clk);
    idle();
    for (int r = 1; r < 32; r++) begin
      rdAddrA = 5'(r);
      #1;
      check(3, $sformatf("bulk clear reg %0d", r), rdDataA,
            ((32'hAAAA_5555 >> r) & 32'd1) != 0 ? 64'd0 : 64'(r) * 64'h0101_0101_0101_0101);
    end

    // R11 and R1: reset mid-run hides old data and ignores a write during reset
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 5'd3; wrData = VD;
    @(negedge clk);
    idle();
    rdAddrA = 5'd3;
    #1;
    check(2, "reg 3 before reset", rdDataA, VD);
    @(negedge clk);
    rst = 1'b1;
    wrEn = 1'b1; wrAddr = 5'd4; wrData = VE;
    @(negedge clk);
    rst = 1'b0;
    idle();
    rdAddrA = 5'd3; rdAddrB = 5'd4;
    #1;
    check(1, "reg 3 after reset", rdDataA, 64'd0);
    check(11, "write during reset ignored", rdDataB, 64'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule